// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two parameter-wide operands (32 bits by default) with one single-bit full adder that is reused once per clock. A start strobe loads both operands in parallel into their own shift registers. The lowest bit of each register goes to the full adder on every clock, starting with the least significant bit. A carry register returns each bit's carry-out as the next bit's carry-in. Each sum bit enters a result shift register from the top, so after the last bit the result register holds the whole sum in its normal bit order.

The block keeps a parallel-in, parallel-out word interface. It can therefore stand in for a wide parallel adder in a word datapath. The cost is a latency of one cycle per bit. In return it needs far less arithmetic logic and has far less leaking area while the datapath sleeps. Only one operation runs at a time. A start strobe that arrives while an operation is in flight is dropped.

Top module: `serial_word_adder`

## Requirements
- R1: After reset `sum_out`, `carry_out` and `done` are all 0.
- R2: A start accepted at clock edge k (start high while idle) makes `done` high after edge k+WIDTH, for exactly one cycle. `done` stays low at every sample before that.
- R3: While `done` is high, {`carry_out`, `sum_out`} equals the (WIDTH+1)-bit sum of the two operands captured at the accepted start.
- R4: A start during an operation is ignored. The result and the timing of `done` stay those of the first operation.
- R5: The carry register is cleared when an operation is loaded, so a carry left by an earlier operation never enters the new one.
- R6: A carry ripples through every bit position. All-ones plus one gives `sum_out` = 0 and `carry_out` = 1.
- R7: After `done`, `sum_out` and `carry_out` hold their values until the next start is accepted.
- R8: Changing the operand ports after the start has been accepted has no effect on the result.
- R9: Asserting reset in the middle of an operation aborts it. Outputs return to 0 and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load both operands and begin an addition when idle |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| sum_out | output | WIDTH | Parallel sum |
| carry_out | output | 1 | Final carry of the addition |
| done | output | 1 | One-cycle pulse when the sum is complete |

## Verification
The bench builds the block with its default WIDTH of 32. This gives the 5-bit counter its full range, so the end-of-count decode at 31 and the full 32-cycle latency are checked exactly. With 32 bits, a carry that enters at bit 0 and leaves at the top crosses every position. The all-ones plus one and top-bit overflow vectors exercise that path. A late start, operand changes during an operation and a mid-operation reset are then injected at fixed cycles within the 32-cycle window.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);
    always_comb begin
        s_bit = a_bit ^ b_bit ^ c_in;
        c_out = (a_bit & b_bit) | (c_in & (a_bit ^ b_bit));
    end
endmodule

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             lsb
);
    logic [WIDTH-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (load) begin
            q_d = par_in;
        end else if (shift) begin
            q_d = {ser_in, q_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q   = q_q;
    assign lsb = q_q[0];

    // R8: after a load the register holds what the port showed at that edge
    p_load_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(par_in));

    // R3: a shift moves every bit down by one position
    p_shift_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));

    // R7: with neither load nor shift the contents stay put
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load) |=> $stable(q));
endmodule

// File: rtl/bsa_seq_ctrl.sv
module bsa_seq_ctrl
    import bsa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.phase = PH_RUN;
                st_d.cnt   = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign load = start && (st_q.phase == PH_IDLE);
    assign step = (st_q.phase == PH_RUN);
    assign done = st_q.done;

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done only follows a cycle of operation
    p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(step));

    // R4: a start while running does not restart the count
    p_busy_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start && st_q.cnt != LAST) |=> (step && st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R2: load and step never coincide
    p_load_step_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));
endmodule

// File: rtl/serial_word_adder.sv
module serial_word_adder #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             done
);
    logic load, step;
    logic a_lsb, b_lsb;
    logic s_bit, c_next;
    logic carry_d, carry_q;
    logic [WIDTH-1:0] a_q, b_q, r_q;
    logic r_lsb;

    bsa_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_opa_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (step),
        .par_in (opa),
        .ser_in (1'b0),
        .q      (a_q),
        .lsb    (a_lsb)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_opb_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (step),
        .par_in (opb),
        .ser_in (1'b0),
        .q      (b_q),
        .lsb    (b_lsb)
    );

    bsa_full_adder u_fa (
        .a_bit (a_lsb),
        .b_bit (b_lsb),
        .c_in  (carry_q),
        .s_bit (s_bit),
        .c_out (c_next)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_res_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (1'b0),
        .shift  (step),
        .par_in ('0),
        .ser_in (s_bit),
        .q      (r_q),
        .lsb    (r_lsb)
    );

    always_comb begin
        carry_d = carry_q;
        if (load)      carry_d = 1'b0;
        else if (step) carry_d = c_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
    end

    assign sum_out   = r_q;
    assign carry_out = carry_q;

    // R5: loading a new operation clears the carry
    p_carry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !carry_out);

    // R7: outputs stay fixed while idle and not loading
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> ($stable(sum_out) && $stable(carry_out)));

    // R6: the top result bit at done is the sum bit of the last cycle
    p_top_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> sum_out[WIDTH-1] == ($past(a_lsb) ^ $past(b_lsb) ^ $past(carry_q)));

    logic unused_bits;
    assign unused_bits = ^{a_q, b_q, r_lsb};
endmodule

// File: tb/serial_word_adder_tb.sv
module serial_word_adder_tb;
    localparam int W = 32;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] opa = '0, opb = '0;
    logic [W-1:0] sum_out;
    logic carry_out, done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_word_adder #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .sum_out(sum_out), .carry_out(carry_out), .done(done)
    );

    // {a, b, expected 33-bit sum}
    localparam logic [96:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 33'h0_0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0001, 33'h1_0000_0000},
        {32'h1234_5678, 32'h1111_1111, 33'h0_2345_6789},
        {32'h8000_0000, 32'h8000_0000, 33'h1_0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 33'h1_FFFF_FFFE},
        {32'hAAAA_AAAA, 32'h5555_5555, 33'h0_FFFF_FFFF},
        {32'h0000_FFFF, 32'h0000_0001, 33'h0_0001_0000},
        {32'hDEAD_BEEF, 32'h0000_0001, 33'h0_DEAD_BEF0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0: plain, 1: extra start mid-run, 2: operand ports change mid-run
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W:0] exp, input int mode, input string req);
        int early_done;
        early_done = 0;
        @(negedge clk);
        opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= W; i++) begin
            if (i == 5 && mode == 1) begin
                opa = ~a; opb = 32'h1357_9BDF; start = 1'b1;
            end else if (i == 5 && mode == 2) begin
                opa = ~a; opb = ~b;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (i < W && done) early_done++;
        end
        start = 1'b0;
        chk({req, " R2 no early done"}, 64'(early_done), 64'd0);
        chk({req, " R2 done high"}, 64'(done), 64'd1);
        chk({req, " R3 result"}, 64'({carry_out, sum_out}), 64'(exp));
        @(negedge clk);
        chk({req, " R2 done pulse ends"}, 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        chk({req, " R7 result held"}, 64'({carry_out, sum_out}), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sum", 64'(sum_out), 64'd0);
        chk("R1 carry", 64'(carry_out), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][96:65], VEC[v][64:33], VEC[v][32:0], 0, "R3 vector");
        end

        // R6: all-ones plus one ripples through every bit
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 33'h1_0000_0000, 0, "R6 ripple");
        // R5: previous carry of 1 must not leak into zero plus zero
        run_op(32'h0000_0000, 32'h0000_0000, 33'h0_0000_0000, 0, "R5 carry cleared");
        // R4: start during an operation is ignored
        run_op(32'h0F0F_0F0F, 32'h0101_0101, 33'h0_1010_1010, 1, "R4 busy start");
        // R8: operand port changes after load have no effect
        run_op(32'h7000_0001, 32'h9000_0003, 33'h1_0000_0004, 2, "R8 port change");

        for (int r = 0; r < 20; r++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom(); rb = $urandom();
            run_op(ra, rb, {1'b0, ra} + {1'b0, rb}, 0, "R3 random");
        end

        // R9: reset in mid-operation aborts
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            opa = 32'hFFFF_FFFF; opb = 32'hFFFF_FFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            chk("R9 sum cleared", 64'(sum_out), 64'd0);
            chk("R9 carry cleared", 64'(carry_out), 64'd0);
            rst_n = 1'b1;
            for (int i = 0; i < W + 4; i++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk("R9 no done after abort", 64'(seen), 64'd0);
        end

        // after abort the block works again
        run_op(32'h0000_0002, 32'h0000_0003, 33'h0_0000_0005, 0, "R9 recover");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule